// File: doc/BRIEF.md
# Reloadable Underflow Interval Timer

This block is an 8-bit down-counting interval timer. It has three parts: a reload register, a working counter and a small control register. Software first writes the reload value. While the timer is stopped, it sets the control register's load bit, which copies the reload value into the working counter. It then sets the run bit. From then on the counter steps down by one on every tick of the selected prescaled clock. When a tick finds the counter at zero, the counter takes the reload value again and the block raises a one-cycle underflow pulse. That pulse can drive an interrupt controller and also start a converter.

A reload value of N gives one underflow every N+1 ticks. Useful values are 1 to 255, so writing 255 divides the tick rate by 256. Every underflow also sets a sticky interrupt flag, which software clears by pulsing `irq_clr`. The prescaler selection can only be changed while the timer is stopped, because changing the tick rate during a count would leave the counter in an unknown state. Every pin is a plain control or status pin. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `uf_timer`

## Requirements
- R1: After reset the counter reads 0, the control readback reads 0x00, and `underflow_o` and `irq_flag_o` are both low.
- R2: When the stored control register has load=1 and run=0, the reload value is copied into the counter on the next clock edge, and `count_o` shows it one cycle after the control write.
- R3: With run=1 and load=0, the counter decrements by one on each prescaler tick. The prescaler starts from zero at the enabling write, so the first decrement happens d cycles after that write, where d is the divisor.
- R4: A tick that finds the counter at 0 reloads it from the reload register and drives `underflow_o` high for exactly one cycle. With reload value N and divisor d, the first underflow comes (N+1)*d cycles after the enabling write, and later underflows follow every (N+1)*d cycles.
- R5: The prescaler select in control bits [1:0] picks the divisor: 00 gives /1, 01 gives /2, 10 gives /4 and 11 gives /8.
- R6: Control write data has run at bit 7, load at bit 6 and the select at bits [1:0]. `mode_o` reads back those same positions, and its other bits read 0.
- R7: A control write made while the stored run bit is 1 leaves the select field unchanged, and the tick rate stays the same. The write still updates the run and load bits.
- R8: Writing the reload register while the timer runs does not change the current count. The new value first appears at the next reload.
- R9: `irq_flag_o` sets in the same cycle that `underflow_o` rises, and a pulse on `irq_clr` clears it. When a clear and an underflow fall in the same cycle, the flag stays set.
- R10: When run=0 and load=0, or when both bits are 1, the counter holds its value and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Write strobe for the reload register |
| base_wdata | input | 8 | Reload value |
| mode_we | input | 1 | Write strobe for the control register |
| mode_wdata | input | 8 | Control write data (run bit 7, load bit 6, select bits 1:0) |
| irq_clr | input | 1 | Clears the sticky interrupt flag when high |
| count_o | output | 8 | Current counter value |
| mode_o | output | 8 | Control register readback |
| underflow_o | output | 1 | One-cycle pulse after each reload on zero |
| irq_flag_o | output | 1 | Sticky interrupt flag |

## Verification
Two events can fall in the same cycle: the counter wrapping on zero, which sets the interrupt flag, and a software clear of that flag. The bench runs the timer with reload 1 and no prescaling. It waits until the counter reads zero, which means the next edge wraps, and asserts `irq_clr` in exactly that cycle. The flag must still be set afterwards. A second clear, issued in a cycle with no wrap, must then drop the flag.

// File: rtl/uf_timer_pkg.sv
package uf_timer_pkg;
  localparam int MODE_W  = 8;
  localparam int RUN_POS = 7;
  localparam int LD_POS  = 6;
  localparam int SEL_W   = 2;
  localparam int PRE_W   = (1 << SEL_W) - 1;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic run;
    logic ld;
    sel_t sel;
  } ctrl_t;
endpackage

// File: rtl/uf_timer_ctrl.sv
module uf_timer_ctrl
  import uf_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [MODE_W-1:0] rdata
);
  ctrl_t ctrl_q;
  logic  unused_rsvd;

  assign unused_rsvd = ^wdata[LD_POS-1:SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q.run <= wdata[RUN_POS];
      ctrl_q.ld  <= wdata[LD_POS];
      if (!ctrl_q.run) begin
        ctrl_q.sel <= wdata[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    rdata                = '0;
    rdata[RUN_POS]       = ctrl_q.run;
    rdata[LD_POS]        = ctrl_q.ld;
    rdata[SEL_W-1:0]     = ctrl_q.sel;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/uf_timer_presc.sv
module uf_timer_presc
  import uf_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  sel_t sel,
  output logic tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (run) begin
      pre_q <= pre_q + 1'b1;
    end else begin
      pre_q <= '0;
    end
  end
endmodule

// File: rtl/uf_timer_count.sv
module uf_timer_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] base,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             uf
);
  logic [CNT_W-1:0] cnt_q;
  logic             uf_q;

  assign wrap = run && tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= wrap;
      if (load) begin
        cnt_q <= base;
      end else if (wrap) begin
        cnt_q <= base;
      end else if (run && tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign count = cnt_q;
  assign uf    = uf_q;
endmodule

// File: rtl/uf_timer_flag.sv
module uf_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set) begin
      flag_q <= 1'b1;
    end else if (clr) begin
      flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/uf_timer.sv
module uf_timer
  import uf_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [CNT_W-1:0]  base_wdata,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              irq_clr,
  output logic [CNT_W-1:0]  count_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              underflow_o,
  output logic              irq_flag_o
);
  ctrl_t            ctrl;
  logic             run_q;
  logic             ld_q;
  sel_t             sel_q;
  logic [CNT_W-1:0] base_q;
  logic             running;
  logic             loading;
  logic             tick;
  logic             wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_we) begin
      base_q <= base_wdata;
    end
  end

  uf_timer_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mode_we),
    .wdata (mode_wdata),
    .ctrl  (ctrl),
    .rdata (mode_o)
  );

  assign run_q   = ctrl.run;
  assign ld_q    = ctrl.ld;
  assign sel_q   = ctrl.sel;
  assign running = run_q && !ld_q;
  assign loading = ld_q && !run_q;

  uf_timer_presc u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .sel   (sel_q),
    .tick  (tick)
  );

  uf_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (loading),
    .run   (running),
    .tick  (tick),
    .base  (base_q),
    .count (count_o),
    .wrap  (wrap),
    .uf    (underflow_o)
  );

  uf_timer_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wrap),
    .clr   (irq_clr),
    .flag  (irq_flag_o)
  );
endmodule

// File: rtl/uf_timer_chk.sv
module uf_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             ld,
  input logic [1:0]       sel,
  input logic [CNT_W-1:0] base,
  input logic [CNT_W-1:0] count,
  input logic             tick,
  input logic             uf,
  input logic             flag,
  input logic             clr
);
  assert_load_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld && !run) |-> count == $past(base));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run && !ld && tick && count != '0) |-> count == $past(count) - CNT_W'(1));

  assert_reload_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uf |-> count == $past(base));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && count != '0) |=> !uf);

  assert_sel_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> $stable(sel));

  assert_flag_on_uf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uf |-> flag);

  assert_flag_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && !uf) |-> !flag);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) == $past(ld)) |-> ($stable(count) && !uf));
endmodule

bind uf_timer uf_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (run_q),
  .ld    (ld_q),
  .sel   (sel_q),
  .base  (base_q),
  .count (count_o),
  .tick  (tick),
  .uf    (underflow_o),
  .flag  (irq_flag_o),
  .clr   (irq_clr)
);

// File: tb/sim_uf_timer.sv
`timescale 1ns/1ps
module sim_uf_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_we = 1'b0;
  logic [7:0] base_wdata = '0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       irq_clr = 1'b0;
  logic [7:0] count_o;
  logic [7:0] mode_o;
  logic       underflow_o;
  logic       irq_flag_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uf_timer u0 (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .irq_clr(irq_clr),
    .count_o(count_o), .mode_o(mode_o), .underflow_o(underflow_o),
    .irq_flag_o(irq_flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr_mode(input logic [7:0] v);
    mode_we = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic wr_base(input logic [7:0] v);
    base_we = 1'b1; base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  // Counts cycles until underflow_o is seen high, starting from cyc0.
  task automatic wait_uf(input int cyc0, output int cyc);
    cyc = cyc0;
    while (!underflow_o && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // Stop, set select, load n, enable; returns at the negedge after the enabling write.
  task automatic start(input int sel, input int n);
    wr_mode(8'h00);
    wr_mode(8'(sel));
    wr_base(8'(n));
    wr_mode(8'h40 | 8'(sel));
    @(negedge clk);
    chk(count_o == 8'(n), "R2 load copies reload value", count_o, n);
    wr_mode(8'h80 | 8'(sel));
  endtask

  task automatic period_pair(input int sel, input int n);
    int cyc;
    int d;
    d = 1 << sel;
    start(sel, n);
    wait_uf(0, cyc);
    chk(cyc == (n + 1) * d, "R4/R5 first underflow delay", cyc, (n + 1) * d);
    @(negedge clk);
    chk(!underflow_o, "R4 pulse lasts one cycle", underflow_o, 0);
    wait_uf(1, cyc);
    chk(cyc == (n + 1) * d, "R4/R5 underflow period", cyc, (n + 1) * d);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int cyc;
    int held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(count_o == 0, "R1 counter after reset", count_o, 0);
    chk(mode_o == 0, "R1 control after reset", mode_o, 0);
    chk(!underflow_o, "R1 underflow after reset", underflow_o, 0);
    chk(!irq_flag_o, "R1 flag after reset", irq_flag_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 field positions and readback
    wr_mode(8'h3E);
    chk(mode_o == 8'h02, "R6 reserved bits read zero", mode_o, 8'h02);
    wr_mode(8'h42);
    chk(mode_o == 8'h42, "R6 load and select readback", mode_o, 8'h42);

    // R3 first decrement d cycles after enable (d=4)
    start(2, 5);
    repeat (3) @(negedge clk);
    chk(count_o == 5, "R3 no decrement before first tick", count_o, 5);
    @(negedge clk);
    chk(count_o == 4, "R3 first decrement at tick", count_o, 4);
    @(negedge clk);
    chk(count_o == 4, "R3 holds between ticks", count_o, 4);

    // R4/R5 exhaustive over reload values at /1
    for (int n = 1; n < 256; n++) period_pair(0, n);
    // R5 other divisors
    for (int s = 1; s < 4; s++) begin
      period_pair(s, 1);
      period_pair(s, 2);
      period_pair(s, 3);
      period_pair(s, 6);
      period_pair(s, 255);
    end

    // R7 select write ignored while running
    start(1, 3);
    wr_mode(8'h82);
    chk(mode_o == 8'h81, "R7 select unchanged while running", mode_o, 8'h81);
    wait_uf(0, cyc);
    @(negedge clk);
    wait_uf(1, cyc);
    chk(cyc == 8, "R7 tick rate unchanged", cyc, 8);

    // R8 reload write while running applies at next reload
    start(0, 3);
    wait_uf(0, cyc);
    wr_base(8'd6);
    chk(count_o == 2, "R8 count unaffected by reload write", count_o, 2);
    wait_uf(1, cyc);
    chk(cyc == 4, "R8 current period keeps old value", cyc, 4);
    @(negedge clk);
    wait_uf(1, cyc);
    chk(cyc == 7, "R8 next period uses new value", cyc, 7);

    // R9 clear colliding with a wrap: set wins
    start(0, 1);
    while (count_o != 0) @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(underflow_o == 1, "R9 wrap occurred in clear cycle", underflow_o, 1);
    chk(irq_flag_o == 1, "R9 set wins over clear", irq_flag_o, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq_flag_o == 0, "R9 clear without wrap", irq_flag_o, 0);
    @(negedge clk);
    chk(irq_flag_o == 1, "R9 flag sets with underflow", irq_flag_o, 1);

    // R10 hold when stopped, and when both bits set
    start(0, 9);
    repeat (3) @(negedge clk);
    wr_mode(8'h00);
    held = count_o;
    repeat (12) @(negedge clk);
    chk(count_o == 8'(held), "R10 hold while stopped", count_o, held);
    chk(!underflow_o, "R10 no underflow while stopped", underflow_o, 0);
    wr_mode(8'hC0);
    repeat (12) @(negedge clk);
    chk(count_o == 8'(held), "R10 hold with run and load both set", count_o, held);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule